// File: doc/BRIEF.md
# Error Barrier Resolution Controller

This block settles pending system errors when an error barrier instruction reaches execution. It keeps one physical and one virtual pending-error flag, each set by a one-cycle raise strobe. When the barrier strobe is accepted, the block resolves both flags in a single cycle. An unmasked error becomes an exception request strobe. A masked error is deferred: its flag is cleared and its syndrome is written into a deferred status word. The physical error goes to the deferred status register. The virtual error goes to the virtual deferred status register, which takes the syndrome that software supplies on a dedicated input.

The barrier orders no memory traffic and does not flush the pipeline. It waits only while the count of outstanding accesses that can still raise an asynchronous abort is non-zero. A small register port reads and writes both status words. Access from exception level 0 faults. Under hypervisor routing, guest accesses to the physical word are redirected to the virtual word.

Top module: `errsync_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, every outcome strobe and both pending flags are 0, and both status words read as 0.
- R2: A barrier strobe sampled at clock edge k in the idle state sets `busy` at edge k. Outcome strobes are high for one cycle after edge k+1. With no abort-capable access outstanding, `done` is high for one cycle after edge k+2, and `busy` falls at that same edge.
- R3: An unmasked pending physical error yields a one-cycle `phys_take` strobe and clears `phys_pending`. The physical status word is left unchanged.
- R4: A masked pending physical error yields a one-cycle `phys_defer` strobe and clears `phys_pending`. The physical status word becomes bit 31 (the A bit) set to 1, with the captured syndrome in bits SYND_W-1:0 and zeros in between.
- R5: An unmasked pending virtual error yields a one-cycle `virt_take` strobe and clears `virt_pending`.
- R6: A masked pending virtual error yields a one-cycle `virt_defer` strobe and clears `virt_pending`. The virtual status word becomes bit 31 set to 1, with `virt_syndrome` in bits SYND_W-1:0.
- R7: When both errors are pending and unmasked, only `phys_take` is raised, and `virt_pending` stays 1.
- R8: While `abort_outstanding` is non-zero after resolution, `busy` stays 1 and `done` stays 0. `done` rises at the first edge that samples the count as zero.
- R9: A barrier strobe that arrives while `busy` is 1 is ignored and produces no second `done`.
- R10: A read or write with `cur_el` = 0 sets `reg_undef` in the next cycle. A read then returns 0, and a write changes no status word.
- R11: With `reg_sel` = 0 (physical word), `cur_el` = 1, `nonsecure` = 1 and `hyp_route` = 1, reads and writes go to the virtual word. At EL2 or above, or with routing off, they reach the physical word.
- R12: `reg_sel` = 1 (virtual word) is usable only at EL2 or above. Below EL2 it sets `reg_undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esb_go | input | 1 | Barrier execute strobe |
| phys_raise | input | 1 | Sets the physical pending flag and captures its syndrome |
| phys_syndrome | input | SYND_W | Physical error syndrome |
| virt_raise | input | 1 | Sets the virtual pending flag |
| virt_syndrome | input | SYND_W | Software-written virtual syndrome |
| phys_masked | input | 1 | Physical error masked at the current level |
| virt_masked | input | 1 | Virtual error masked |
| cur_el | input | 2 | Current exception level |
| nonsecure | input | 1 | Non-secure state |
| hyp_route | input | 1 | Hypervisor routing of guest status accesses |
| abort_outstanding | input | CNT_W | Count of outstanding abort-capable accesses |
| reg_rd | input | 1 | Status register read |
| reg_wr | input | 1 | Status register write |
| reg_sel | input | 1 | 0 physical word, 1 virtual word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| reg_undef | output | 1 | Undefined-access fault, one cycle after the access |
| phys_take | output | 1 | Physical exception request strobe |
| phys_defer | output | 1 | Physical deferral strobe |
| virt_take | output | 1 | Virtual exception request strobe |
| virt_defer | output | 1 | Virtual deferral strobe |
| phys_pending | output | 1 | Physical pending flag |
| virt_pending | output | 1 | Virtual pending flag |
| busy | output | 1 | Barrier in progress |
| done | output | 1 | Barrier complete pulse |

## Verification
The bench builds the block with SYND_W = 24, CNT_W = 4 and HAS_EL2 = 1. The 24-bit syndrome leaves a band of zero bits between the syndrome and the A bit, so a misplaced field shows up. Having EL2 makes the routing and the virtual-word access rules reachable. The 4-bit counter lets a short drain from three outstanding accesses hold the barrier open.

// File: rtl/errsync_pkg.sv
package errsync_pkg;
  localparam int REG_W = 32;
  localparam int A_POS = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_RES, ST_WAIT} seq_t;
  typedef enum logic [1:0] {TGT_NONE, TGT_DSR, TGT_VDSR} tgt_t;
endpackage

// File: rtl/errsync_seq.sv
module errsync_seq
  import errsync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] outst,
  output logic             resolve,
  output logic             busy,
  output logic             done
);
  seq_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_RES;
          busy  <= 1'b1;
        end
        ST_RES:  state <= ST_WAIT;
        ST_WAIT: if (outst == '0) begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign resolve = (state == ST_RES);

  // R8: completion only after the abort-capable count was seen empty
  a_r8_done_after_drain: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(outst == '0));
  // R9: completion is a single pulse
  a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: busy drops together with done
  a_r2_busy_ends: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/errsync_pend.sv
module errsync_pend #(
  parameter int SYND_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p_raise,
  input  logic [SYND_W-1:0] p_synd_in,
  input  logic              v_raise,
  input  logic              p_mask,
  input  logic              v_mask,
  input  logic              resolve,
  output logic              p_pend,
  output logic              v_pend,
  output logic [SYND_W-1:0] p_synd,
  output logic              p_take,
  output logic              p_defer,
  output logic              v_take,
  output logic              v_defer,
  output logic              p_def_now,
  output logic              v_def_now
);
  logic p_take_now, v_take_now;

  always_comb begin
    p_take_now = resolve && p_pend && !p_mask;
    p_def_now  = resolve && p_pend &&  p_mask;
    // physical request wins; virtual one remains pending
    v_take_now = resolve && v_pend && !v_mask && !p_take_now;
    v_def_now  = resolve && v_pend &&  v_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_pend  <= 1'b0;
      v_pend  <= 1'b0;
      p_synd  <= '0;
      p_take  <= 1'b0;
      p_defer <= 1'b0;
      v_take  <= 1'b0;
      v_defer <= 1'b0;
    end else begin
      if (p_raise) begin
        p_pend <= 1'b1;
        p_synd <= p_synd_in;
      end else if (p_take_now || p_def_now) begin
        p_pend <= 1'b0;
      end
      if (v_raise)                       v_pend <= 1'b1;
      else if (v_take_now || v_def_now)  v_pend <= 1'b0;
      p_take  <= p_take_now;
      p_defer <= p_def_now;
      v_take  <= v_take_now;
      v_defer <= v_def_now;
    end
  end

  // R7: a virtual request that lost to a physical one stays pending
  a_r7_virt_kept: assert property (@(posedge clk) disable iff (rst)
    (p_take && $past(v_pend && !v_mask)) |-> v_pend);
  // R3: a taken physical error no longer pends unless re-raised
  a_r3_take_clears: assert property (@(posedge clk) disable iff (rst)
    (p_take && !$past(p_raise)) |-> !p_pend);
  // R4: a deferred physical error no longer pends unless re-raised
  a_r4_defer_clears: assert property (@(posedge clk) disable iff (rst)
    (p_defer && !$past(p_raise)) |-> !p_pend);
endmodule

// File: rtl/errsync_regs.sv
module errsync_regs
  import errsync_pkg::*;
#(
  parameter int SYND_W  = 24,
  parameter bit HAS_EL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p_def_now,
  input  logic [SYND_W-1:0] p_def_synd,
  input  logic              v_def_now,
  input  logic [SYND_W-1:0] v_def_synd,
  input  logic [1:0]        cur_el,
  input  logic              nonsec,
  input  logic              route,
  input  logic              rd,
  input  logic              wr,
  input  logic              sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              undef
);
  localparam int GAP_W = A_POS - SYND_W;

  logic              dsr_a, vdsr_a;
  logic [SYND_W-1:0] dsr_s, vdsr_s;
  tgt_t              tgt;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[A_POS-1:SYND_W];

  function automatic logic [REG_W-1:0] pack(input logic a, input logic [SYND_W-1:0] s);
    return {a, {GAP_W{1'b0}}, s};
  endfunction

  always_comb begin
    tgt = TGT_NONE;
    if (cur_el != 2'd0) begin
      if (!sel) begin
        if (HAS_EL2 && cur_el == 2'd1 && nonsec && route) tgt = TGT_VDSR;
        else                                             tgt = TGT_DSR;
      end else if (HAS_EL2 && cur_el >= 2'd2) begin
        tgt = TGT_VDSR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsr_a  <= 1'b0;
      dsr_s  <= '0;
      vdsr_a <= 1'b0;
      vdsr_s <= '0;
      rdata  <= '0;
      undef  <= 1'b0;
    end else begin
      // hardware deferral has priority over a software write in the same cycle
      if (p_def_now) begin
        dsr_a <= 1'b1;
        dsr_s <= p_def_synd;
      end else if (wr && tgt == TGT_DSR) begin
        dsr_a <= wdata[A_POS];
        dsr_s <= wdata[SYND_W-1:0];
      end
      if (v_def_now) begin
        vdsr_a <= 1'b1;
        vdsr_s <= v_def_synd;
      end else if (wr && tgt == TGT_VDSR) begin
        vdsr_a <= wdata[A_POS];
        vdsr_s <= wdata[SYND_W-1:0];
      end
      undef <= (rd || wr) && (tgt == TGT_NONE);
      rdata <= '0;
      if (rd) begin
        case (tgt)
          TGT_DSR:  rdata <= pack(dsr_a, dsr_s);
          TGT_VDSR: rdata <= pack(vdsr_a, vdsr_s);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R4: deferral leaves the A bit set
  a_r4_dsr_a_set: assert property (@(posedge clk) disable iff (rst)
    $past(p_def_now) |-> dsr_a);
  // R6: virtual deferral leaves the virtual A bit set
  a_r6_vdsr_a_set: assert property (@(posedge clk) disable iff (rst)
    $past(v_def_now) |-> vdsr_a);
  // R10: any access from EL0 faults one cycle later
  a_r10_el0_faults: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && cur_el == 2'd0) |=> undef);
  // R12: the virtual word faults below EL2
  a_r12_vsel_low: assert property (@(posedge clk) disable iff (rst)
    ((rd || wr) && sel && cur_el < 2'd2) |=> undef);
endmodule

// File: rtl/errsync_ctrl.sv
module errsync_ctrl
  import errsync_pkg::*;
#(
  parameter int SYND_W  = 24,
  parameter int CNT_W   = 4,
  parameter bit HAS_EL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              esb_go,
  input  logic              phys_raise,
  input  logic [SYND_W-1:0] phys_syndrome,
  input  logic              virt_raise,
  input  logic [SYND_W-1:0] virt_syndrome,
  input  logic              phys_masked,
  input  logic              virt_masked,
  input  logic [1:0]        cur_el,
  input  logic              nonsecure,
  input  logic              hyp_route,
  input  logic [CNT_W-1:0]  abort_outstanding,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_undef,
  output logic              phys_take,
  output logic              phys_defer,
  output logic              virt_take,
  output logic              virt_defer,
  output logic              phys_pending,
  output logic              virt_pending,
  output logic              busy,
  output logic              done
);
  logic              resolve;
  logic              p_def_now, v_def_now;
  logic [SYND_W-1:0] p_synd;

  errsync_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(esb_go), .outst(abort_outstanding),
    .resolve(resolve), .busy(busy), .done(done)
  );

  errsync_pend #(.SYND_W(SYND_W)) u_pend (
    .clk(clk), .rst(rst),
    .p_raise(phys_raise), .p_synd_in(phys_syndrome), .v_raise(virt_raise),
    .p_mask(phys_masked), .v_mask(virt_masked), .resolve(resolve),
    .p_pend(phys_pending), .v_pend(virt_pending), .p_synd(p_synd),
    .p_take(phys_take), .p_defer(phys_defer),
    .v_take(virt_take), .v_defer(virt_defer),
    .p_def_now(p_def_now), .v_def_now(v_def_now)
  );

  errsync_regs #(.SYND_W(SYND_W), .HAS_EL2(HAS_EL2)) u_regs (
    .clk(clk), .rst(rst),
    .p_def_now(p_def_now), .p_def_synd(p_synd),
    .v_def_now(v_def_now), .v_def_synd(virt_syndrome),
    .cur_el(cur_el), .nonsec(nonsecure), .route(hyp_route),
    .rd(reg_rd), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .undef(reg_undef)
  );

  // R2: outcome strobes only appear inside a barrier
  a_r2_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
    (phys_take || phys_defer || virt_take || virt_defer) |-> busy);
  // R3/R4: a physical error is either taken or deferred, never both
  a_r4_phys_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phys_take && phys_defer));
endmodule

// File: tb/errsync_ctrl_tb.sv
module errsync_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          esb_go = 0, phys_raise = 0, virt_raise = 0;
  logic [SW-1:0] phys_syndrome = '0, virt_syndrome = '0;
  logic          phys_masked = 0, virt_masked = 0;
  logic [1:0]    cur_el = 2'd1;
  logic          nonsecure = 0, hyp_route = 0;
  logic [CW-1:0] abort_outstanding = '0;
  logic          reg_rd = 0, reg_wr = 0, reg_sel = 0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_undef, phys_take, phys_defer, virt_take, virt_defer;
  logic          phys_pending, virt_pending, busy, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  errsync_ctrl #(.SYND_W(SW), .CNT_W(CW), .HAS_EL2(1'b1)) u_dut (.*);

  // {praise, vraise, pmask, vmask, ptake, pdefer, vtake, vdefer, ppend, vpend}
  localparam logic [9:0] VEC [0:8] = '{
    10'b0000_0000_00,
    10'b1000_1000_00,
    10'b1010_0100_00,
    10'b0100_0010_00,
    10'b0101_0001_00,
    10'b1100_1000_01,
    10'b0001_0001_00,
    10'b1111_0101_00,
    10'b1110_0110_00
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_access(input logic wr, input logic [1:0] el, input logic sel,
                            input logic [31:0] wd);
    @(negedge clk);
    cur_el = el; reg_sel = sel; reg_wdata = wd;
    reg_rd = !wr; reg_wr = wr;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
  endtask

  task automatic barrier(input logic pr, input logic vr, input logic pm, input logic vm,
                         input logic [SW-1:0] ps, input logic [SW-1:0] vs);
    @(negedge clk);
    phys_raise = pr; virt_raise = vr; phys_syndrome = ps; virt_syndrome = vs;
    phys_masked = pm; virt_masked = vm;
    @(negedge clk);
    phys_raise = 0; virt_raise = 0; esb_go = 1;
    @(negedge clk);
    esb_go = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 busy/done", {30'd0, busy, done}, 32'd0);
    check("R1 strobes", {28'd0, phys_take, phys_defer, virt_take, virt_defer}, 32'd0);
    check("R1 pending", {30'd0, phys_pending, virt_pending}, 32'd0);
    reg_access(0, 2'd1, 0, '0);
    check("R1 phys word", reg_rdata, 32'd0);
    reg_access(0, 2'd2, 1, '0);
    check("R1 virt word", reg_rdata, 32'd0);

    // R2..R7: table walk
    for (int i = 0; i < 9; i++) begin
      logic [9:0] v;
      logic [SW-1:0] ps, vs;
      v = VEC[i];
      ps = 24'hA50000 | SW'(i);
      vs = 24'h5A0000 | SW'(i);
      barrier(v[9], v[8], v[7], v[6], ps, vs);
      check($sformatf("R2 R3 R4 R5 R6 R7 strobes vec%0d", i),
            {28'd0, phys_take, phys_defer, virt_take, virt_defer}, {28'd0, v[5:2]});
      check($sformatf("R2 busy vec%0d", i), {31'd0, busy}, 32'd1);
      @(negedge clk);
      check($sformatf("R2 done vec%0d", i), {30'd0, done, busy}, 32'd2);
      check($sformatf("R7 pending vec%0d", i), {30'd0, phys_pending, virt_pending},
            {30'd0, v[1:0]});
      if (v[4]) begin
        reg_access(0, 2'd1, 0, '0);
        check($sformatf("R4 phys word vec%0d", i), reg_rdata, 32'h8000_0000 | 32'(ps));
      end
      if (v[2]) begin
        reg_access(0, 2'd2, 1, '0);
        check($sformatf("R6 virt word vec%0d", i), reg_rdata, 32'h8000_0000 | 32'(vs));
      end
    end

    // R3: taken physical error leaves the physical word unchanged (last deferral was vec8)
    barrier(1, 0, 0, 0, 24'h111111, 24'h0);
    @(negedge clk);
    reg_access(0, 2'd3, 0, '0);
    check("R3 word unchanged", reg_rdata, 32'h8000_0000 | 32'hA50008);

    // R8: done waits for outstanding abort-capable accesses
    abort_outstanding = 4'd3;
    barrier(0, 0, 0, 0, '0, '0);
    repeat (4) @(negedge clk);
    check("R8 held", {30'd0, done, busy}, 32'd1);
    abort_outstanding = 4'd0;
    @(negedge clk);
    check("R8 release", {30'd0, done, busy}, 32'd2);

    // R9: second strobe during busy ignored
    begin
      int ndone = 0;
      @(negedge clk); esb_go = 1;
      @(negedge clk); esb_go = 1;
      @(negedge clk); esb_go = 1;
      @(negedge clk); esb_go = 0;
      for (int c = 0; c < 8; c++) begin
        if (done) ndone++;
        @(negedge clk);
      end
      check("R9 single done", ndone, 32'd1);
    end

    // R10: EL0 access faults, returns zero, writes nothing
    reg_access(0, 2'd0, 0, '0);
    check("R10 read undef", {31'd0, reg_undef}, 32'd1);
    check("R10 read zero", reg_rdata, 32'd0);
    reg_access(1, 2'd0, 0, 32'h0000_1234);
    check("R10 write undef", {31'd0, reg_undef}, 32'd1);
    reg_access(0, 2'd1, 0, '0);
    check("R10 write ignored", reg_rdata, 32'h8000_0000 | 32'hA50008);

    // R11: routed guest access reaches the virtual word
    nonsecure = 1; hyp_route = 1;
    reg_access(1, 2'd1, 0, 32'h8000_0ABC);
    reg_access(0, 2'd2, 1, '0);
    check("R11 routed write", reg_rdata, 32'h8000_0ABC);
    reg_access(0, 2'd1, 0, '0);
    check("R11 routed read", reg_rdata, 32'h8000_0ABC);
    reg_access(0, 2'd2, 0, '0);
    check("R11 EL2 direct", reg_rdata, 32'h8000_0000 | 32'hA50008);
    hyp_route = 0;
    reg_access(0, 2'd1, 0, '0);
    check("R11 route off", reg_rdata, 32'h8000_0000 | 32'hA50008);
    nonsecure = 0;

    // R12: virtual word below EL2
    reg_access(0, 2'd1, 1, '0);
    check("R12 undef", {31'd0, reg_undef}, 32'd1);
    check("R12 zero", reg_rdata, 32'd0);

    // R1: reset clears status words and pending flags
    barrier(1, 1, 1, 0, 24'h0F0F0F, 24'h0);
    @(negedge clk); virt_raise = 1;
    @(negedge clk); virt_raise = 0; rst = 1;
    @(negedge clk); rst = 0;
    check("R1 reset pending", {30'd0, phys_pending, virt_pending}, 32'd0);
    reg_access(0, 2'd1, 0, '0);
    check("R1 reset word", reg_rdata, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule